// File: doc/BRIEF.md
# Break Address Comparator Bank

This block holds a bank of programmable break addresses and watches the system address bus. Each entry stores an enable flag and a word address within a 1 MB ROM space. On every clock the address bus is compared with all entries at once. If an enabled entry matches while the ROM chip-select is active, the block raises a non-maskable interrupt request on the following clock edge. It also latches a vector with one bit per entry, so the service routine can tell which entries fired.

Software programs the entries through a 256-byte register window on an 8-bit data bus. Entry n occupies window offsets 4n to 4n+3. Offset 4n+0 is the enable byte, with bit 7 as the enable flag. Offset 4n+1 holds A19..A16 in bits 3..0. Offset 4n+2 holds A15..A8. Offset 4n+3 holds A7..A2 in bits 7..2. Every address bit sits at its own bit position, with no shifting. Any write into the window clears a pending request, and so does a pulse on the clear input.

Top module: `bkpt_bank`

## Requirements
- R1: After reset `nmi` is 0, `hit` is 0, and every entry's enable byte reads back as 0x00.
- R2: A read of offset 4n+0 returns {enable,7'b0}. Offset 4n+1 returns {4'b0,A19..A16}. Offset 4n+2 returns A15..A8. Offset 4n+3 returns {A7..A2,2'b00}. Bits written to unimplemented positions read back as 0.
- R3: An enabled entry whose stored A19..A2 equals `bus_addr[19:2]` while `rom_cs` is 1 sets `nmi` and `hit[n]` on the next rising clock edge.
- R4: An entry whose enable bit is 0 never sets its `hit` bit or `nmi`.
- R5: While `rom_cs` is 0, no entry matches.
- R6: `bus_addr[23:20]` and `bus_addr[1:0]` do not affect matching.
- R7: Once set, `nmi` and the `hit` bits stay set until a clear. Further matches OR new bits into `hit`, and `nmi` is 1 exactly when `hit` is non-zero.
- R8: A write to any window offset (`cs`=1, `wr`=1), or `nmi_clr`=1, clears `nmi` and `hit` at the next edge. A match in that same cycle still sets its bits, and a set takes priority over a clear.
- R9: When several enabled entries match the same address, all their `hit` bits are set together.
- R10: Window offsets at or above 4 times the entry count (0x80..0xFF with 32 entries) store nothing and read as 0x00. Writes to those offsets change no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Register window select |
| wr | input | 1 | Write strobe (read when 0) |
| a | input | 8 | Window offset |
| d | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| bus_addr | input | 24 | System address bus |
| rom_cs | input | 1 | ROM chip-select, qualifies matches |
| nmi_clr | input | 1 | Explicit request clear |
| nmi | output | 1 | Non-maskable interrupt request |
| hit | output | 32 | Latched per-entry match vector |

## Verification
The assertions assume that a match can only occur while `rom_cs` is high. They also assume that `cs`, `wr` and `nmi_clr` are the only ways to clear a request. From these they derive hold, clear and rise rules. The bench changes inputs only on falling edges. It keeps `rom_cs` low whenever it issues a clear that it expects to stick. It raises `rom_cs` together with a clear only in the single test of set-over-clear priority.

// File: rtl/bkpt_pkg.sv
// Shared constants and types for the break address comparator bank.
// Assumes the compared field is A19..A2 of the system bus.
package bkpt_pkg;
    localparam int CMP_HI = 19;
    localparam int CMP_LO = 2;
    localparam int CMP_W  = CMP_HI - CMP_LO + 1;
    typedef logic [CMP_W-1:0] cmp_addr_t;
endpackage

// File: rtl/bkpt_regfile.sv
// Entry storage and register window decode.
// Assumes window offset = {entry index, byte select}. Entries beyond N are unimplemented.
module bkpt_regfile
    import bkpt_pkg::*;
#(
    parameter int N      = 32,
    parameter int WIN_AW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [WIN_AW-1:0]     a,
    input  logic [7:0]            d,
    output logic [N-1:0]          en_o,
    output cmp_addr_t [N-1:0]     addr_o,
    output logic [7:0]            rdata
);
    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0] sel;
    logic             in_range;

    // Decode the entry index and whether it names an implemented entry.
    always_comb begin
        sel      = a[IDX_W+1:2];
        in_range = (32'(a[WIN_AW-1:2]) < N);
    end

    // Store the enable flag and address fields at their natural bit positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= '0;
            addr_o <= '0;
        end else if (wr_en && in_range) begin
            case (a[1:0])
                2'd0: en_o[sel]          <= d[7];
                2'd1: addr_o[sel][17:14] <= d[3:0];
                2'd2: addr_o[sel][13:6]  <= d;
                default: addr_o[sel][5:0] <= d[7:2];
            endcase
        end
    end

    // Return the stored byte, with unimplemented bits as zero.
    always_comb begin
        rdata = 8'h00;
        if (in_range) begin
            case (a[1:0])
                2'd0: rdata = {en_o[sel], 7'b0};
                2'd1: rdata = {4'b0, addr_o[sel][17:14]};
                2'd2: rdata = addr_o[sel][13:6];
                default: rdata = {addr_o[sel][5:0], 2'b00};
            endcase
        end
    end
endmodule

// File: rtl/bkpt_cmp.sv
// One entry comparator: enabled, ROM-qualified equality on A19..A2.
// Assumes cur_addr is already sliced to the compared field.
module bkpt_cmp
    import bkpt_pkg::*;
(
    input  logic      en,
    input  logic      rom_cs,
    input  cmp_addr_t ref_addr,
    input  cmp_addr_t cur_addr,
    output logic      match
);
    // Flag a coincidence only for enabled entries during ROM accesses.
    always_comb match = en && rom_cs && (ref_addr == cur_addr);
endmodule

// File: rtl/bkpt_irq.sv
// Request and hit-vector register. Sticky until cleared, and a set beats a clear.
// Assumes match is combinational from the current bus cycle.
module bkpt_irq #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] match,
    input  logic         clr,
    output logic         nmi,
    output logic [N-1:0] hit
);
    // Accumulate matches and drop the old state on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit <= '0;
            nmi <= 1'b0;
        end else begin
            hit <= (clr ? '0 : hit) | match;
            nmi <= (clr ? 1'b0 : nmi) | (|match);
        end
    end
endmodule

// File: rtl/bkpt_bank.sv
// Top of the break address comparator bank: window decode, N comparators, request register.
// Assumes a single clock, with the bus address and rom_cs stable around each rising edge.
module bkpt_bank
    import bkpt_pkg::*;
#(
    parameter int N       = 32,
    parameter int BUS_AW  = 24,
    parameter int WIN_AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic [WIN_AW-1:0] a,
    input  logic [7:0]        d,
    output logic [7:0]        rdata,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              rom_cs,
    input  logic              nmi_clr,
    output logic              nmi,
    output logic [N-1:0]      hit
);
    logic                 wr_en;
    logic                 clr;
    logic [N-1:0]         en_vec;
    cmp_addr_t [N-1:0]    ref_vec;
    cmp_addr_t            cur_addr;
    logic [N-1:0]         match;
    logic [7:0]           rd_raw;
    logic                 unused_bus;

    // Form window strobes, the compared address slice and gated read data.
    always_comb begin
        wr_en      = cs && wr;
        clr        = wr_en || nmi_clr;
        cur_addr   = bus_addr[CMP_HI:CMP_LO];
        rdata      = (cs && !wr) ? rd_raw : 8'h00;
        unused_bus = ^{bus_addr[BUS_AW-1:CMP_HI+1], bus_addr[CMP_LO-1:0]};
    end

    bkpt_regfile #(.N(N), .WIN_AW(WIN_AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .a      (a),
        .d      (d),
        .en_o   (en_vec),
        .addr_o (ref_vec),
        .rdata  (rd_raw)
    );

    for (genvar g = 0; g < N; g++) begin : g_cmp
        bkpt_cmp u_cmp (
            .en       (en_vec[g]),
            .rom_cs   (rom_cs),
            .ref_addr (ref_vec[g]),
            .cur_addr (cur_addr),
            .match    (match[g])
        );
    end

    bkpt_irq #(.N(N)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .match (match),
        .clr   (clr),
        .nmi   (nmi),
        .hit   (hit)
    );
endmodule

// File: rtl/bkpt_bank_chk.sv
// Port-level checker for bkpt_bank. Assumes matches need rom_cs, and clears come only from cs/wr/nmi_clr.
module bkpt_bank_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs,
    input logic         wr,
    input logic         rom_cs,
    input logic         nmi_clr,
    input logic         nmi,
    input logic [N-1:0] hit
);
    // R7: the request and the hit vector agree.
    p_nmi_eq_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi == (hit != '0));

    // R7: a pending request holds without a clear.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi && !nmi_clr && !(cs && wr) |=> nmi);

    // R8: a clear without a possible match drops the request.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_clr || (cs && wr)) && !rom_cs |=> !nmi);

    // R5: no new request without a ROM access.
    p_no_rom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cs && !nmi |=> !nmi);

    // R3: a rising request follows a ROM-qualified cycle.
    p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> $past(rom_cs));
endmodule

bind bkpt_bank bkpt_bank_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .wr      (wr),
    .rom_cs  (rom_cs),
    .nmi_clr (nmi_clr),
    .nmi     (nmi),
    .hit     (hit)
);

// File: tb/bkpt_bank_tb_top.sv
// Self-checking bench for bkpt_bank: a vector table walk, then directed cases.
module bkpt_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, wr = 1'b0;
    logic [7:0]  a = '0, d = '0;
    logic [7:0]  rdata;
    logic [23:0] bus_addr = '0;
    logic        rom_cs = 1'b0, nmi_clr = 1'b0;
    logic        nmi;
    logic [31:0] hit;
    int          tests = 0, fails = 0;

    always #10 clk = ~clk;

    bkpt_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .a(a), .d(d), .rdata(rdata),
        .bus_addr(bus_addr), .rom_cs(rom_cs), .nmi_clr(nmi_clr), .nmi(nmi), .hit(hit)
    );

    // {bus address, rom_cs, expected hit}
    localparam logic [56:0] VECS [0:7] = '{
        {24'h012344, 1'b1, 32'h0000_0201},
        {24'hF12347, 1'b1, 32'h0000_0201},
        {24'h012348, 1'b1, 32'h0000_0000},
        {24'h012344, 1'b0, 32'h0000_0000},
        {24'h0FFFFC, 1'b1, 32'h0000_0020},
        {24'h000000, 1'b1, 32'h0000_0000},
        {24'h080000, 1'b1, 32'h8000_0000},
        {24'h7FFFFD, 1'b1, 32'h0000_0020}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] off, input logic [7:0] val);
        @(negedge clk); cs = 1; wr = 1; a = off; d = val;
        @(negedge clk); cs = 0; wr = 0;
    endtask

    task automatic rd_chk(input logic [7:0] off, input logic [7:0] exp, input string tag);
        @(negedge clk); cs = 1; wr = 0; a = off;
        #1 chk(tag, {24'h0, rdata}, {24'h0, exp});
        cs = 0;
    endtask

    task automatic prog(input int idx, input logic [19:0] ad, input logic en);
        wr_byte(8'(idx*4),   {en, 7'h7F});
        wr_byte(8'(idx*4+1), {4'hF, ad[19:16]});
        wr_byte(8'(idx*4+2), ad[15:8]);
        wr_byte(8'(idx*4+3), {ad[7:2], 2'b11});
    endtask

    // Present one bus cycle, then sample after the capturing edge.
    task automatic bus_cycle(input logic [23:0] ad, input logic rom);
        @(negedge clk); bus_addr = ad; rom_cs = rom;
        @(negedge clk); rom_cs = 0;
    endtask

    task automatic clear_pulse;
        @(negedge clk); nmi_clr = 1;
        @(negedge clk); nmi_clr = 0;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 nmi", {31'b0, nmi}, 32'h0);
        chk("R1 hit", hit, 32'h0);
        rd_chk(8'h00, 8'h00, "R1 enable byte entry0");
        rd_chk(8'h7C, 8'h00, "R1 enable byte entry31");

        prog(0, 20'h12344, 1'b1);
        prog(5, 20'hFFFFC, 1'b1);
        prog(7, 20'h00000, 1'b0);
        prog(9, 20'h12344, 1'b1);
        prog(31, 20'h80000, 1'b1);

        // R2: readback layout with unimplemented bits as zero
        rd_chk(8'h00, 8'h80, "R2 byte0");
        rd_chk(8'h01, 8'h01, "R2 byte1");
        rd_chk(8'h02, 8'h23, "R2 byte2");
        rd_chk(8'h03, 8'h44, "R2 byte3");
        rd_chk(8'h1C, 8'h00, "R2 disabled entry byte0");

        // R3 R4 R5 R6 R9: table walk
        for (int i = 0; i < 8; i++) begin
            bus_cycle(VECS[i][56:33], VECS[i][32]);
            chk($sformatf("R3/R4/R5/R6/R9 vec%0d hit", i), hit, VECS[i][31:0]);
            chk($sformatf("R3 vec%0d nmi", i), {31'b0, nmi}, {31'b0, VECS[i][31:0] != 0});
            clear_pulse();
            chk($sformatf("R8 vec%0d clr", i), {31'b0, nmi}, 32'h0);
        end

        // R7: hold without clear, and accumulate
        bus_cycle(24'h0FFFFC, 1'b1);
        repeat (4) @(negedge clk);
        chk("R7 held hit", hit, 32'h0000_0020);
        bus_cycle(24'h080000, 1'b1);
        chk("R7 accumulate", hit, 32'h8000_0020);
        chk("R7 nmi", {31'b0, nmi}, 32'h1);

        // R10 R8: write to an unimplemented offset clears without touching entries
        wr_byte(8'hFE, 8'h00);
        chk("R8 window write clears", {31'b0, nmi}, 32'h0);
        chk("R8 window write clears hit", hit, 32'h0);
        wr_byte(8'h80, 8'h00);
        rd_chk(8'hFE, 8'h00, "R10 unimplemented read");
        rd_chk(8'h00, 8'h80, "R10 no alias to entry0");
        bus_cycle(24'h012344, 1'b1);
        chk("R10 entry0 still fires", hit, 32'h0000_0201);

        // R8: set wins over a simultaneous clear
        clear_pulse();
        bus_cycle(24'h0FFFFC, 1'b1);
        @(negedge clk); bus_addr = 24'h012344; rom_cs = 1; nmi_clr = 1;
        @(negedge clk); rom_cs = 0; nmi_clr = 0;
        chk("R8 set beats clear", hit, 32'h0000_0201);
        chk("R8 set beats clear nmi", {31'b0, nmi}, 32'h1);

        // R4: disabling entry0 removes its hit
        wr_byte(8'h00, 8'h00);
        bus_cycle(24'h012344, 1'b1);
        chk("R4 disabled entry0", hit, 32'h0000_0200);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule